// File: doc/BRIEF.md
# Vector Element Interleave Unit

This unit zips two source vectors into one destination register group twice as long. Destination slot `i` takes element `i/2` of the second source when `i` is even, and element `i/2` of the first source when `i` is odd. The destination holds `2*NSRC` elements. The body/tail boundary is twice the active vector length. Per-slot masking is indexed by destination position, not by source position.

An operation starts with a one-cycle `start` pulse while the unit is idle. At that edge the unit decodes the instruction word, checks legality and captures all operands. A legal operation loads the old destination contents. It then writes one destination slot per clock, lowest slot first. Each slot follows one of four cases:
- Slots below the start index keep their old value.
- Slots at or past `2*vl` follow the tail policy.
- Body slots that are masked off follow the mask policy.
- All remaining slots receive the interleaved source element.

An illegal configuration leaves the destination untouched. It reports the illegal flag together with `done` on the following cycle.

Register-file access and the group-overlap calculation live outside this block. An overlap-ok input carries the result of that calculation.

Top module: `vec_interleave`

## Requirements
- R1: An unmasked body slot `i` receives element `i/2` of `src2_i` when `i` is even, and element `i/2` of `src1_i` when `i` is odd. Element `k` of a flat bus occupies bits `[k*DW +: DW]`.
- R2: Slots with index at or above `2*vl_i` are tail slots; all slots with start index <= i < `2*vl_i` are body slots.
- R3: A tail slot keeps its old destination value when `ta_i`=0 and becomes all ones when `ta_i`=1.
- R4: When masking is on, body slot `i` uses `mask_i[i]`, a destination-indexed mask. A slot with `mask_i[i]`=0 keeps its old value when `ma_i`=0 and becomes all ones when `ma_i`=1.
- R5: Slots with index below `vstart_i` keep their old destination value, whatever the mask and tail settings.
- R6: Instruction bit 25 is the unmasked flag. When it is 1, `mask_i` has no effect on the result.
- R7: A source group size code of 3 (eight registers) on `lmul_i` is illegal. The illegal flag is raised and `dst_o` is left unchanged. Codes 0..2 (one, two or four registers) are legal.
- R8: `overlap_ok_i`=0 is illegal, with the destination unchanged.
- R9: The element width code `sew_i` is 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. Codes 0 to 2 are always legal. Code 3 is legal only when `ew64_en_i`=1.
- R10: The instruction word must carry bits[31:26]=111110, bits[14:12]=010 and bits[6:0]=1010111; any other word is illegal.
- R11: `done_o` is high for exactly one cycle. After an accepting edge, a legal operation raises it after 2*NSRC further edges, and an illegal one at the very next edge. `illegal_o` is valid only together with `done_o`.
- R12: `vstart_clr_o` is raised with `done_o` for legal operations only, reporting that the start index is reset to zero.
- R13: A `start` pulse while `busy_o` is high is ignored. The running operation completes on its captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| insn_i | input | 32 | Instruction word |
| src1_i | input | NSRC*DW | First source elements |
| src2_i | input | NSRC*DW | Second source elements |
| old_dst_i | input | 2*NSRC*DW | Previous destination contents |
| mask_i | input | 2*NSRC | Per-destination-slot mask bits |
| vl_i | input | $clog2(NSRC+1) | Active source length |
| vstart_i | input | $clog2(2*NSRC+1) | First destination slot to write |
| ta_i | input | 1 | Tail policy (1 = fill ones) |
| ma_i | input | 1 | Mask policy (1 = fill ones) |
| lmul_i | input | 2 | Source group size code |
| sew_i | input | 2 | Element width code |
| ew64_en_i | input | 1 | 64-bit element support enabled |
| overlap_ok_i | input | 1 | Register overlap acceptable |
| dst_o | output | 2*NSRC*DW | Destination register contents |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Illegal instruction, valid with done |
| vstart_clr_o | output | 1 | Start index cleared, valid with done |

## Verification
A wrong slot count or a mis-set body/tail boundary shows up on `dst_o` at the `done` pulse as a shifted or wrongly filled element pair. A stuck progress counter instead shows as a `done` that arrives early or late against the fixed 2*NSRC-edge latency. A legality slip appears within one cycle of `start`: either `done` and `illegal_o` fail to rise at the next edge, or the destination changes when it must hold. Every policy combination is checked against a slot-by-slot model, so an error in a single slot is caught at the first operation that reaches that slot's case.

// File: rtl/vzi_pkg.sv
package vzi_pkg;

  typedef enum logic [1:0] {EK_PRE, EK_BODY, EK_OFF, EK_TAIL} ekind_t;

  // fixed fields of the zip instruction: funct6, funct3, major opcode
  localparam logic [31:0] ZIP_FIELDS = 32'hFC00_707F;
  localparam logic [31:0] ZIP_VALUE  = {6'b111110, 11'd0, 3'b010, 5'd0, 7'b1010111};

  function automatic logic insn_is_zip(input logic [31:0] w);
    return (w & ZIP_FIELDS) == ZIP_VALUE;
  endfunction

  function automatic logic width_ok(input logic [1:0] sew, input logic en64);
    return (sew != 2'd3) || en64;
  endfunction

  // slot class: prestart first, then tail, then mask
  function automatic ekind_t classify(input int i, input int vs, input int evl,
                                      input logic unmasked, input logic mbit);
    if (i < vs)                   return EK_PRE;
    else if (i >= evl)            return EK_TAIL;
    else if (!unmasked && !mbit)  return EK_OFF;
    else                          return EK_BODY;
  endfunction

endpackage

// File: rtl/vzi_legal.sv
module vzi_legal (
  input  logic [31:0] insn_i,
  input  logic [1:0]  lmul_i,
  input  logic [1:0]  sew_i,
  input  logic        ew64_en_i,
  input  logic        overlap_ok_i,
  output logic        ok_o
);
  import vzi_pkg::*;

  logic enc_ok, grp_ok, ew_ok;

  assign enc_ok = insn_is_zip(insn_i);
  assign grp_ok = (lmul_i != 2'd3);
  assign ew_ok  = width_ok(sew_i, ew64_en_i);
  assign ok_o   = enc_ok && grp_ok && ew_ok && overlap_ok_i;
endmodule

// File: rtl/vzi_ctrl.sv
module vzi_ctrl #(
  parameter int NDST = 16,
  localparam int IW = $clog2(NDST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ok_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic          vclr_o
);
  logic last;

  assign accept_o = start_i && !busy_o;
  assign last     = busy_o && (idx_o == IW'(NDST - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o    <= 1'b0;
      idx_o     <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      vclr_o    <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      vclr_o    <= 1'b0;
      if (accept_o) begin
        if (ok_i) begin
          busy_o <= 1'b1;
          idx_o  <= '0;
        end else begin
          done_o    <= 1'b1;
          illegal_o <= 1'b1;
        end
      end else if (busy_o) begin
        if (last) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          vclr_o <= 1'b1;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R11
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> done_o);
  // R12
  vclr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vclr_o |-> (done_o && !illegal_o));
endmodule

// File: rtl/vzi_pick.sv
module vzi_pick #(
  parameter int NSRC = 8,
  parameter int DW   = 16,
  localparam int NDST = 2 * NSRC,
  localparam int IW   = $clog2(NDST),
  localparam int VLW  = $clog2(NSRC + 1),
  localparam int VSW  = $clog2(NDST + 1)
) (
  input  logic [IW-1:0]        idx_i,
  input  logic [NSRC*DW-1:0]   src1_i,
  input  logic [NSRC*DW-1:0]   src2_i,
  input  logic [DW-1:0]        old_i,
  input  logic [NDST-1:0]      mask_i,
  input  logic [VLW-1:0]       vl_i,
  input  logic [VSW-1:0]       vstart_i,
  input  logic                 unmasked_i,
  input  logic                 ta_i,
  input  logic                 ma_i,
  output vzi_pkg::ekind_t      kind_o,
  output logic [DW-1:0]        wdata_o
);
  import vzi_pkg::*;

  logic [IW-2:0] j;
  logic [DW-1:0] e1, e2;

  assign j  = idx_i[IW-1:1];
  assign e1 = src1_i[int'(j)*DW +: DW];
  assign e2 = src2_i[int'(j)*DW +: DW];

  always_comb begin
    kind_o = classify(int'(idx_i), int'(vstart_i), 2 * int'(vl_i), unmasked_i, mask_i[idx_i]);
    unique case (kind_o)
      EK_PRE:  wdata_o = old_i;
      EK_TAIL: wdata_o = ta_i ? '1 : old_i;
      EK_OFF:  wdata_o = ma_i ? '1 : old_i;
      default: wdata_o = idx_i[0] ? e1 : e2;
    endcase
  end
endmodule

// File: rtl/vec_interleave.sv
module vec_interleave #(
  parameter int NSRC = 8,
  parameter int DW   = 16,
  localparam int NDST = 2 * NSRC,
  localparam int IW   = $clog2(NDST),
  localparam int VLW  = $clog2(NSRC + 1),
  localparam int VSW  = $clog2(NDST + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [31:0]          insn_i,
  input  logic [NSRC*DW-1:0]   src1_i,
  input  logic [NSRC*DW-1:0]   src2_i,
  input  logic [NDST*DW-1:0]   old_dst_i,
  input  logic [NDST-1:0]      mask_i,
  input  logic [VLW-1:0]       vl_i,
  input  logic [VSW-1:0]       vstart_i,
  input  logic                 ta_i,
  input  logic                 ma_i,
  input  logic [1:0]           lmul_i,
  input  logic [1:0]           sew_i,
  input  logic                 ew64_en_i,
  input  logic                 overlap_ok_i,
  output logic [NDST*DW-1:0]   dst_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 illegal_o,
  output logic                 vstart_clr_o
);
  import vzi_pkg::*;

  logic               ok, accept, load;
  logic [IW-1:0]      idx;
  logic [NSRC*DW-1:0] src1_q, src2_q;
  logic [NDST-1:0]    mask_q;
  logic [VLW-1:0]     vl_q;
  logic [VSW-1:0]     vstart_q;
  logic               unmasked_q, ta_q, ma_q;
  logic [DW-1:0]      dst_q [NDST];
  logic [DW-1:0]      old_elem, wdata;
  ekind_t             kind;

  vzi_legal u_legal (
    .insn_i(insn_i), .lmul_i(lmul_i), .sew_i(sew_i),
    .ew64_en_i(ew64_en_i), .overlap_ok_i(overlap_ok_i), .ok_o(ok)
  );

  vzi_ctrl #(.NDST(NDST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ok_i(ok),
    .accept_o(accept), .busy_o(busy_o), .idx_o(idx),
    .done_o(done_o), .illegal_o(illegal_o), .vclr_o(vstart_clr_o)
  );

  assign load = accept && ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src1_q     <= '0;
      src2_q     <= '0;
      mask_q     <= '0;
      vl_q       <= '0;
      vstart_q   <= '0;
      unmasked_q <= 1'b0;
      ta_q       <= 1'b0;
      ma_q       <= 1'b0;
    end else if (load) begin
      src1_q     <= src1_i;
      src2_q     <= src2_i;
      mask_q     <= mask_i;
      vl_q       <= vl_i;
      vstart_q   <= vstart_i;
      unmasked_q <= insn_i[25];
      ta_q       <= ta_i;
      ma_q       <= ma_i;
    end
  end

  assign old_elem = dst_q[idx];

  vzi_pick #(.NSRC(NSRC), .DW(DW)) u_pick (
    .idx_i(idx), .src1_i(src1_q), .src2_i(src2_q), .old_i(old_elem),
    .mask_i(mask_q), .vl_i(vl_q), .vstart_i(vstart_q),
    .unmasked_i(unmasked_q), .ta_i(ta_q), .ma_i(ma_q),
    .kind_o(kind), .wdata_o(wdata)
  );

  for (genvar e = 0; e < NDST; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            dst_q[e] <= '0;
      else if (load)                         dst_q[e] <= old_dst_i[e*DW +: DW];
      else if (busy_o && idx == IW'(e))      dst_q[e] <= wdata;
    end
    assign dst_o[e*DW +: DW] = dst_q[e];
  end

  // R5
  prestart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && kind == EK_PRE) |-> (wdata == old_elem));
  // R7
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(dst_o));
  // R13
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(mask_q) && $stable(vl_q) && $stable(src1_q)));
endmodule

// File: tb/sim_vec_interleave.sv
module sim_vec_interleave;
  localparam int PERIOD = 10;
  localparam int NSRC = 8;
  localparam int DW   = 16;
  localparam int NDST = 2 * NSRC;
  localparam int VLW  = $clog2(NSRC + 1);
  localparam int VSW  = $clog2(NDST + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0]        insn;
  logic [NSRC*DW-1:0] src1, src2;
  logic [NDST*DW-1:0] old_dst, dst;
  logic [NDST-1:0]    mask;
  logic [VLW-1:0]     vl;
  logic [VSW-1:0]     vstart;
  logic ta, ma, en64, ovl;
  logic [1:0] lmul, sew;
  logic busy, done, illegal, vclr;

  always #(PERIOD / 2) clk = ~clk;

  vec_interleave #(.NSRC(NSRC), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .insn_i(insn),
    .src1_i(src1), .src2_i(src2), .old_dst_i(old_dst), .mask_i(mask),
    .vl_i(vl), .vstart_i(vstart), .ta_i(ta), .ma_i(ma), .lmul_i(lmul),
    .sew_i(sew), .ew64_en_i(en64), .overlap_ok_i(ovl), .dst_o(dst),
    .busy_o(busy), .done_o(done), .illegal_o(illegal), .vstart_clr_o(vclr)
  );

  typedef struct {
    logic [NDST*DW-1:0] dst;
    bit                 ill;
    int                 due;
    string              tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [NDST*DW-1:0] shadow = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NDST*DW-1:0] act, input logic [NDST*DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(input logic unm);
    return {6'b111110, unm, 5'd4, 5'd8, 3'b010, 5'd12, 7'b1010111};
  endfunction

  task automatic fill(input int seed);
    for (int k = 0; k < NSRC; k++) begin
      src1[k*DW +: DW] = 16'h1000 + 16'(seed * 32 + k);
      src2[k*DW +: DW] = 16'h2000 + 16'(seed * 32 + k);
    end
    for (int e = 0; e < NDST; e++) old_dst[e*DW +: DW] = 16'hA000 + 16'(seed * 32 + e);
  endtask

  // monitor: pops one expectation per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R13", "unexpected done", '0, '0);
      end else begin
        exp_t x;
        x = q.pop_front();
        check(dst == x.dst, x.tag, "dst", dst, x.dst);
        check(illegal == x.ill, x.tag, "illegal", illegal, x.ill);
        check(vclr == !x.ill, {x.tag, " R12"}, "vstart_clr", vclr, !x.ill);
        check(cyc == x.due, {x.tag, " R11"}, "done cycle", cyc, x.due);
      end
    end
  end

  task automatic run_op(input string tag, input bit poke);
    exp_t x;
    bit legal, unm;
    int sc;
    legal = insn[31:26] == 6'h3E && insn[14:12] == 3'd2 && insn[6:0] == 7'h57 &&
            lmul != 2'd3 && (sew != 2'd3 || en64) && ovl;
    unm = insn[25];
    if (legal) begin
      for (int e = 0; e < NDST; e++) begin
        logic [DW-1:0] o, v;
        o = old_dst[e*DW +: DW];
        if (e < int'(vstart))            v = o;
        else if (e >= 2 * int'(vl))      v = ta ? {DW{1'b1}} : o;
        else if (unm || mask[e])         v = (e % 2 == 1) ? src1[(e/2)*DW +: DW] : src2[(e/2)*DW +: DW];
        else                             v = ma ? {DW{1'b1}} : o;
        x.dst[e*DW +: DW] = v;
      end
    end else begin
      x.dst = shadow;
    end
    shadow = x.dst;
    x.ill  = !legal;
    x.tag  = tag;
    @(negedge clk);
    sc    = cyc;
    x.due = sc + 1 + (legal ? NDST : 0);
    q.push_back(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; src1 = '1; mask = '0; vl = '0; insn = mk_insn(1'b0);
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic defaults(input int seed);
    fill(seed);
    insn = mk_insn(1'b1); mask = '0; vl = VLW'(NSRC); vstart = '0;
    ta = 1'b0; ma = 1'b0; lmul = 2'd1; sew = 2'd1; en64 = 1'b0; ovl = 1'b1;
  endtask

  initial begin
    defaults(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dst == '0, "R11 reset", "dst", dst, '0);
    check({busy, done, illegal, vclr} == 4'b0, "R11 reset", "flags", {busy, done, illegal, vclr}, '0);

    defaults(1);                                   run_op("R1 full", 0);
    defaults(2); vl = 5;                           run_op("R2 R3 tail undisturbed", 0);
    defaults(3); vl = 3; ta = 1;                   run_op("R3 tail ones", 0);
    defaults(4); insn = mk_insn(1'b0); mask = 16'b1010_0110_1100_0011;
                                                   run_op("R4 mask undisturbed", 0);
    defaults(5); insn = mk_insn(1'b0); mask = 16'h3C5A; ma = 1; vl = 6; ta = 1;
                                                   run_op("R4 mask ones", 0);
    defaults(6); vstart = 5; ta = 1; vl = 7;       run_op("R5 prestart", 0);
    defaults(7); vstart = 3; insn = mk_insn(1'b0); mask = '0; ma = 1;
                                                   run_op("R5 prestart masked", 0);
    defaults(8); insn = mk_insn(1'b1); mask = '0; ma = 1;
                                                   run_op("R6 unmasked", 0);
    defaults(9); lmul = 2'd3;                      run_op("R7 group of eight", 0);
    defaults(10); lmul = 2'd2;                     run_op("R7 group of four", 0);
    defaults(11); ovl = 1'b0;                      run_op("R8 overlap", 0);
    defaults(12); sew = 2'd3;                      run_op("R9 w64 disabled", 0);
    defaults(13); sew = 2'd3; en64 = 1'b1;         run_op("R9 w64 enabled", 0);
    defaults(14); sew = 2'd0;                      run_op("R9 w8", 0);
    defaults(15); insn[31:26] = 6'b010010;         run_op("R10 funct6", 0);
    defaults(16); insn[14:12] = 3'b000;            run_op("R10 funct3", 0);
    defaults(17); vl = 4;                          run_op("R13 start while busy", 1);
    defaults(18); vl = 0; ta = 1;                  run_op("R2 empty body", 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule